// File: doc/BRIEF.md
# Serial EEPROM Write-Protect Controller

This block is the command-side control logic of a 32K-byte serial EEPROM. A front end that has already shifted in and decoded each instruction hands it over as a single-cycle strobe. The strobe carries an opcode, a 15-bit array address and a data byte. The block keeps the write-enable latch and the nonvolatile protection bits. It decides whether each programming request may proceed, and it times the internal write cycle that follows an accepted request.

An accepted array write leaves the block as a one-cycle strobe to the memory array, carrying the address and the data. A status write changes no array location. It runs the same timed cycle, and its new protection bits take effect when that cycle ends. The status byte is always present on an output, so a read-status instruction needs no action here. While a write cycle runs, the status byte reads as all ones.

Protection is chosen by a two-bit level. The level guards the top quarter, the top half, or the whole address space. A separate enable bit, together with the active-low write-protect pin, can lock the status register itself.

Top module: `eeprom_wp_ctrl`

## Requirements
- R1: After reset, the status byte reads 0x00, busy is low and no array strobe is issued. This means the latch, both level bits and the lock-enable bit are all 0.
- R2: Opcode encoding on cmd_op is 0 no-op, 1 set latch, 2 clear latch, 3 read status, 4 status write, 5 array write; 6 and 7 act as no-ops. Opcode 1, when idle, sets status bit 1.
- R3: Opcode 2, when idle, clears the write-enable latch whatever the level of wp_n.
- R4: A status write or an array write received while the latch is clear has no effect on any output.
- R5: An accepted array write produces array_wr high for exactly one cycle, in the cycle after the strobe, carrying the strobe's address and data. busy is high for exactly WRITE_CYCLES cycles, starting in that same cycle.
- R6: While idle, the status byte is {lock-enable, 3'b000, level[1:0], latch, 1'b0}, with bit 0 showing busy.
- R7: While busy, the status byte reads 0xFF.
- R8: Level 0 protects nothing. Level 1 protects 0x6000..0x7FFF, level 2 protects 0x4000..0x7FFF and level 3 protects all addresses. A write to a protected address is not issued.
- R9: A programming request with the latch set that is rejected for protection clears the latch and starts no cycle.
- R10: Every command received while busy, including opcodes 1 and 2, is ignored.
- R11: The latch clears when an accepted write cycle ends.
- R12: A status write takes bit 7 of the data as lock-enable, bit 3 as level[1] and bit 2 as level[0], and ignores the other bits. The new values appear only after the cycle ends.
- R13: With lock-enable 1 and wp_n low, a status write is rejected as in R9. Array writes do not depend on wp_n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_op | input | 3 | Opcode (see R2) |
| cmd_addr | input | 15 | Array address for opcode 5 |
| cmd_data | input | 8 | Array data or new status bits |
| wp_n | input | 1 | Active-low write-protect pin |
| status_byte | output | 8 | Status byte for reading |
| busy | output | 1 | Internal write cycle in progress |
| array_wr | output | 1 | One-cycle array write strobe |
| array_wr_addr | output | 15 | Address of the array write |
| array_wr_data | output | 8 | Data of the array write |

## Verification
The properties assume that cmd_valid is a clean one-cycle strobe, and that the opcode, address and data are stable and known whenever it is high. The range property also assumes the level bits are visible on the status byte in the idle cycle before a strobe, which holds because a cycle can only start from idle. The stimulus drives every input from a task just after the falling edge, holds it for one whole cycle, and returns cmd_valid to zero between commands. It issues commands during busy periods on purpose, to exercise the ignore rule.

// File: rtl/eeprom_wp_pkg.sv
package eeprom_wp_pkg;

  typedef enum logic [2:0] {
    OP_NOP     = 3'd0,
    OP_WEL_SET = 3'd1,
    OP_WEL_CLR = 3'd2,
    OP_STAT_RD = 3'd3,
    OP_STAT_WR = 3'd4,
    OP_ARR_WR  = 3'd5
  } wp_op_e;

  localparam int unsigned STAT_W      = 8;
  localparam int unsigned BIT_BUSY    = 0;
  localparam int unsigned BIT_LATCH   = 1;
  localparam int unsigned BIT_LVL_LO  = 2;
  localparam int unsigned BIT_LVL_HI  = 3;
  localparam int unsigned BIT_LOCK_EN = 7;

endpackage

// File: rtl/wp_range_check.sv
module wp_range_check #(
  parameter int unsigned ADDR_W = 15
) (
  input  logic [1:0]        level,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  localparam logic [ADDR_W:0] SPAN  = (ADDR_W+1)'(1) << ADDR_W;
  localparam logic [ADDR_W:0] HALF  = SPAN >> 1;
  localparam logic [ADDR_W:0] QUART = SPAN >> 2;
  localparam logic [ADDR_W-1:0] TOP_QUARTER = ADDR_W'(HALF + QUART);
  localparam logic [ADDR_W-1:0] TOP_HALF    = ADDR_W'(HALF);

  always_comb begin
    unique case (level)
      2'b00:   hit = 1'b0;
      2'b01:   hit = (addr >= TOP_QUARTER);
      2'b10:   hit = (addr >= TOP_HALF);
      default: hit = 1'b1;
    endcase
  end
endmodule

// File: rtl/wp_cycle_timer.sv
module wp_cycle_timer #(
  parameter int unsigned CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int unsigned CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(CYCLES - 1);

  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign done = busy_q && (cnt_q == '0);
  assign busy = busy_q;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (start) begin
      busy_d = 1'b1;
      cnt_d  = LOAD;
    end else if (done) begin
      busy_d = 1'b0;
    end else if (busy_q) begin
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end
endmodule

// File: rtl/wp_status_fmt.sv
module wp_status_fmt
  import eeprom_wp_pkg::*;
(
  input  logic              busy,
  input  logic              lock_en,
  input  logic [1:0]        level,
  input  logic              latch,
  output logic [STAT_W-1:0] stat
);
  always_comb begin
    stat = '0;
    if (busy) begin
      stat = '1;
    end else begin
      stat[BIT_LOCK_EN] = lock_en;
      stat[BIT_LVL_HI]  = level[1];
      stat[BIT_LVL_LO]  = level[0];
      stat[BIT_LATCH]   = latch;
      stat[BIT_BUSY]    = 1'b0;
    end
  end
endmodule

// File: rtl/eeprom_wp_ctrl.sv
module eeprom_wp_ctrl
  import eeprom_wp_pkg::*;
#(
  parameter int unsigned ADDR_W       = 15,
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned WRITE_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic              wp_n,
  output logic [STAT_W-1:0] status_byte,
  output logic              busy,
  output logic              array_wr,
  output logic [ADDR_W-1:0] array_wr_addr,
  output logic [DATA_W-1:0] array_wr_data
);
  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  wp_op_e op;
  assign op = wp_op_e'(cmd_op);

  // state
  logic              latch_q, latch_d;
  logic [1:0]        level_q, level_d;
  logic              lock_q, lock_d;
  logic              pend_q, pend_d;
  logic [1:0]        pend_level_q, pend_level_d;
  logic              pend_lock_q, pend_lock_d;
  logic              stb_q, stb_d;
  logic [ADDR_W-1:0] stb_addr_q, stb_addr_d;
  logic [DATA_W-1:0] stb_data_q, stb_data_d;

  logic tmr_start, tmr_busy, tmr_done;
  logic addr_hit;
  logic stat_locked;

  wp_range_check #(.ADDR_W(ADDR_W)) u_range (
    .level (level_q),
    .addr  (cmd_addr),
    .hit   (addr_hit)
  );

  wp_cycle_timer #(.CYCLES(WRITE_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (rst_int_n),
    .start (tmr_start),
    .busy  (tmr_busy),
    .done  (tmr_done)
  );

  wp_status_fmt u_fmt (
    .busy    (tmr_busy),
    .lock_en (lock_q),
    .level   (level_q),
    .latch   (latch_q),
    .stat    (status_byte)
  );

  assign stat_locked = lock_q && !wp_n;

  // next state
  always_comb begin
    latch_d      = latch_q;
    level_d      = level_q;
    lock_d       = lock_q;
    pend_d       = pend_q;
    pend_level_d = pend_level_q;
    pend_lock_d  = pend_lock_q;
    stb_d        = 1'b0;
    stb_addr_d   = stb_addr_q;
    stb_data_d   = stb_data_q;
    tmr_start    = 1'b0;

    if (tmr_busy) begin
      if (tmr_done) begin
        latch_d = 1'b0;
        if (pend_q) begin
          level_d = pend_level_q;
          lock_d  = pend_lock_q;
          pend_d  = 1'b0;
        end
      end
    end else if (cmd_valid) begin
      unique case (op)
        OP_WEL_SET: latch_d = 1'b1;
        OP_WEL_CLR: latch_d = 1'b0;
        OP_STAT_WR: begin
          if (latch_q) begin
            if (stat_locked) begin
              latch_d = 1'b0;
            end else begin
              tmr_start    = 1'b1;
              pend_d       = 1'b1;
              pend_level_d = {cmd_data[BIT_LVL_HI], cmd_data[BIT_LVL_LO]};
              pend_lock_d  = cmd_data[BIT_LOCK_EN];
            end
          end
        end
        OP_ARR_WR: begin
          if (latch_q) begin
            if (addr_hit) begin
              latch_d = 1'b0;
            end else begin
              tmr_start  = 1'b1;
              stb_d      = 1'b1;
              stb_addr_d = cmd_addr;
              stb_data_d = cmd_data;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      latch_q      <= 1'b0;
      level_q      <= 2'b00;
      lock_q       <= 1'b0;
      pend_q       <= 1'b0;
      pend_level_q <= 2'b00;
      pend_lock_q  <= 1'b0;
      stb_q        <= 1'b0;
      stb_addr_q   <= '0;
      stb_data_q   <= '0;
    end else begin
      latch_q      <= latch_d;
      level_q      <= level_d;
      lock_q       <= lock_d;
      pend_q       <= pend_d;
      pend_level_q <= pend_level_d;
      pend_lock_q  <= pend_lock_d;
      stb_q        <= stb_d;
      stb_addr_q   <= stb_addr_d;
      stb_data_q   <= stb_data_d;
    end
  end

  assign busy          = tmr_busy;
  assign array_wr      = stb_q;
  assign array_wr_addr = stb_addr_q;
  assign array_wr_data = stb_data_q;

endmodule

// File: rtl/wp_ctrl_chk.sv
module wp_ctrl_chk #(
  parameter int unsigned ADDR_W       = 15,
  parameter int unsigned WRITE_CYCLES = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic [2:0]        cmd_op,
  input logic [7:0]        status_byte,
  input logic              busy,
  input logic              array_wr,
  input logic [ADDR_W-1:0] array_wr_addr
);
  int busy_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_len <= 0;
    else if (busy) busy_len <= busy_len + 1;
    else           busy_len <= 0;
  end

  function automatic logic guarded(input logic [1:0] lvl, input logic [ADDR_W-1:0] a);
    int unsigned span, ai;
    span = 1 << ADDR_W;
    ai   = int'(a);
    case (lvl)
      2'd0:    return 1'b0;
      2'd1:    return ai >= (span / 4) * 3;
      2'd2:    return ai >= span / 2;
      default: return 1'b1;
    endcase
  endfunction

  p_strobe_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    array_wr |=> !array_wr);

  p_strobe_opens_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    array_wr |-> $rose(busy));

  p_cycle_length_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_len == WRITE_CYCLES));

  p_busy_reads_ones_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (status_byte == 8'hFF));

  p_idle_layout_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (status_byte[6:4] == 3'b000 && !status_byte[0]));

  p_no_write_unlatched_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd5 && !busy && !status_byte[1]) |=> !array_wr);

  p_clear_latch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd2 && !busy) |=> (!busy && !status_byte[1]));

  p_range_guard_r8: assert property (@(posedge clk) disable iff (!rst_n)
    array_wr |-> !guarded($past(status_byte[3:2]), array_wr_addr));

endmodule

bind eeprom_wp_ctrl wp_ctrl_chk #(
  .ADDR_W(ADDR_W),
  .WRITE_CYCLES(WRITE_CYCLES)
) u_wp_ctrl_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cmd_valid     (cmd_valid),
  .cmd_op        (cmd_op),
  .status_byte   (status_byte),
  .busy          (busy),
  .array_wr      (array_wr),
  .array_wr_addr (array_wr_addr)
);

// File: tb/tb_eeprom_wp_ctrl.sv
module tb_eeprom_wp_ctrl;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid;
  logic [2:0]  cmd_op;
  logic [14:0] cmd_addr;
  logic [7:0]  cmd_data;
  logic        wp_n;
  logic [7:0]  status_byte;
  logic        busy, array_wr;
  logic [14:0] array_wr_addr;
  logic [7:0]  array_wr_data;

  always #4 clk = ~clk;

  eeprom_wp_ctrl #(.WRITE_CYCLES(N)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .wp_n(wp_n),
    .status_byte(status_byte), .busy(busy), .array_wr(array_wr),
    .array_wr_addr(array_wr_addr), .array_wr_data(array_wr_data)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // behavioural model state
  int m_wel, m_lvl, m_lock, m_rem, m_stb, m_saddr, m_sdata, m_pend, m_plvl, m_plock;

  function automatic bit prot(int lvl, int a);
    if (lvl == 0) return 0;
    if (lvl == 1) return a >= 24576;
    if (lvl == 2) return a >= 16384;
    return 1;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic model_step(bit v, int op, int a, int d, bit w);
    m_stb = 0;
    if (m_rem > 0) begin
      m_rem--;
      if (m_rem == 0) begin
        m_wel = 0;
        if (m_pend) begin m_lvl = m_plvl; m_lock = m_plock; m_pend = 0; end
      end
    end else if (v) begin
      case (op)
        1: m_wel = 1;
        2: m_wel = 0;
        4: if (m_wel) begin
             if (m_lock && !w) m_wel = 0;
             else begin m_rem = N; m_pend = 1; m_plvl = (d >> 2) & 3; m_plock = (d >> 7) & 1; end
           end
        5: if (m_wel) begin
             if (prot(m_lvl, a)) m_wel = 0;
             else begin m_rem = N; m_stb = 1; m_saddr = a; m_sdata = d; end
           end
        default: ;
      endcase
    end
  endtask

  function automatic int m_status();
    if (m_rem > 0) return 255;
    return (m_lock << 7) | (m_lvl << 2) | (m_wel << 1);
  endfunction

  task automatic compare();
    chk(int'(status_byte) == m_status(), (m_rem > 0) ? "R7 status" : "R6 status",
        status_byte, m_status());
    chk(busy == (m_rem > 0), "R5 busy", busy, m_rem > 0);
    chk(array_wr == m_stb, "R5 strobe", array_wr, m_stb);
    if (m_stb) begin
      chk(int'(array_wr_addr) == m_saddr, "R5 addr", array_wr_addr, m_saddr);
      chk(int'(array_wr_data) == m_sdata, "R5 data", array_wr_data, m_sdata);
    end
  endtask

  // one clock: drive after falling edge, model at rising edge, compare at next falling edge
  task automatic cyc(bit v, int op, int a, int d, bit w);
    cmd_valid = v; cmd_op = 3'(op); cmd_addr = 15'(a); cmd_data = 8'(d); wp_n = w;
    @(posedge clk);
    model_step(v, op, a, d, w);
    @(negedge clk);
    compare();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 1);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 4 * N && busy; i++) cyc(0, 0, 0, 0, 1);
  endtask

  initial begin
    cmd_valid = 0; cmd_op = 0; cmd_addr = 0; cmd_data = 0; wp_n = 1;
    m_wel = 0; m_lvl = 0; m_lock = 0; m_rem = 0; m_stb = 0;
    m_saddr = 0; m_sdata = 0; m_pend = 0; m_plvl = 0; m_plock = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle(4);
    // R1 reset state
    chk(status_byte == 8'h00 && !busy && !array_wr, "R1 reset", status_byte, 0);

    // R4 programming without latch
    cyc(1, 5, 15'h0100, 8'h11, 1);
    cyc(0, 0, 0, 0, 1);
    chk(!array_wr && !busy, "R4 array write unlatched", array_wr, 0);
    cyc(1, 4, 0, 8'h8C, 1);
    idle(N + 2);
    chk(status_byte == 8'h00, "R4 status write unlatched", status_byte, 0);

    // R2 set latch, R3 clear with wp_n low
    cyc(1, 1, 0, 0, 1);
    chk(status_byte == 8'h02, "R2 latch set", status_byte, 8'h02);
    cyc(1, 7, 0, 0, 1);
    chk(status_byte == 8'h02, "R2 opcode 7 no-op", status_byte, 8'h02);
    cyc(1, 2, 0, 0, 0);
    chk(status_byte == 8'h00, "R3 clear with wp_n low", status_byte, 0);

    // R5 accepted array write
    cyc(1, 1, 0, 0, 1);
    cyc(1, 5, 15'h1234, 8'hA5, 1);
    chk(array_wr && array_wr_addr == 15'h1234 && array_wr_data == 8'hA5, "R5 strobe",
        {array_wr_addr, array_wr_data}, {15'h1234, 8'hA5});
    chk(status_byte == 8'hFF, "R7 busy status", status_byte, 8'hFF);
    // R10 commands during busy
    cyc(1, 2, 0, 0, 1);
    cyc(1, 1, 0, 0, 1);
    cyc(1, 5, 15'h0001, 8'h33, 1);
    chk(!array_wr, "R10 write while busy", array_wr, 0);
    wait_idle();
    chk(status_byte == 8'h00, "R11 latch cleared after cycle", status_byte, 0);

    // R12 status write, only bits 7,3,2 taken
    cyc(1, 1, 0, 0, 1);
    cyc(1, 4, 0, 8'h77, 1);
    chk(status_byte == 8'hFF, "R12 pending while busy", status_byte, 8'hFF);
    wait_idle();
    chk(status_byte == 8'h04, "R12 level 1", status_byte, 8'h04);

    // R8 level 1 boundary, R9 rejection
    cyc(1, 1, 0, 0, 1);
    cyc(1, 5, 15'h6000, 8'h01, 1);
    chk(!array_wr && !busy && status_byte == 8'h04, "R9 protected reject", status_byte, 8'h04);
    cyc(1, 1, 0, 0, 1);
    cyc(1, 5, 15'h5FFF, 8'h02, 1);
    chk(array_wr, "R8 level 1 below range", array_wr, 1);
    wait_idle();

    // level 2
    cyc(1, 1, 0, 0, 1);
    cyc(1, 4, 0, 8'h08, 1);
    wait_idle();
    cyc(1, 1, 0, 0, 1);
    cyc(1, 5, 15'h4000, 8'h03, 1);
    chk(!array_wr && status_byte == 8'h08, "R8 level 2 reject", status_byte, 8'h08);
    cyc(1, 1, 0, 0, 1);
    cyc(1, 5, 15'h3FFF, 8'h04, 0);
    chk(array_wr, "R13 array write with wp_n low", array_wr, 1);
    wait_idle();

    // level 3 with lock enable
    cyc(1, 1, 0, 0, 1);
    cyc(1, 4, 0, 8'h8C, 1);
    wait_idle();
    chk(status_byte == 8'h8C, "R12 lock and level 3", status_byte, 8'h8C);
    cyc(1, 1, 0, 0, 1);
    cyc(1, 5, 15'h0000, 8'h05, 1);
    chk(!array_wr && status_byte == 8'h8C, "R8 level 3 reject", status_byte, 8'h8C);

    // R13 locked status write
    cyc(1, 1, 0, 0, 0);
    cyc(1, 4, 0, 8'h00, 0);
    cyc(0, 0, 0, 0, 0);
    chk(!busy && status_byte == 8'h8C, "R13 locked status write", status_byte, 8'h8C);
    cyc(1, 1, 0, 0, 1);
    cyc(1, 4, 0, 8'h00, 1);
    wait_idle();
    chk(status_byte == 8'h00, "R13 unlocked with wp_n high", status_byte, 0);

    // level 0 array write at top address
    cyc(1, 1, 0, 0, 1);
    cyc(1, 5, 15'h7FFF, 8'hC3, 1);
    chk(array_wr && array_wr_addr == 15'h7FFF, "R8 level 0 top", array_wr_addr, 15'h7FFF);
    wait_idle();
    idle(2);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule